// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the system clock into CAN time quanta and walks every nominal bit through four segments in a fixed order: a one-quantum synchronisation segment, a propagation segment, phase segment 1 and phase segment 2. At the end of phase segment 1 it samples the received line and publishes the bit value with a one-clock strobe. At the first clock of every synchronisation segment it raises a bit-boundary strobe that the transmitter uses to launch its next bit.

Two configuration words program the block. The quantum word selects the clock prescaler and the synchronisation jump width. The segment word selects the propagation and phase lengths, and it enables an optional three-sample majority vote.

A recessive-to-dominant edge on the received line realigns the bit. When the protocol logic reports an idle bus, the edge restarts the bit outright. Otherwise it lengthens phase segment 1 or shortens phase segment 2 by no more than the jump width, and only once per bit.

The sequencer has four states. `SEG_SYNC` (code 0) always moves to `SEG_PROP` (1) after one quantum. When the propagation length is zero it moves straight to `SEG_PH1` (2) instead. `SEG_PROP` moves to `SEG_PH1` when its quanta are used up. `SEG_PH1` moves to `SEG_PH2` (3) on its last quantum, which is the sample point. `SEG_PH2` returns to `SEG_SYNC` on its last quantum. Two transitions can come from any state:
- a hard sync jumps to `SEG_SYNC`;
- a late edge in `SEG_PH2` jumps to `SEG_SYNC` early.

Top module: `can_bit_timing`

## Requirements
- R1: One quantum lasts D+1 clocks, where D = `cfg_qreg[5:0]` (0 to 63, so division by 1 to 64). `tq_tick` is high in the last clock of each quantum.
- R2: The segment lengths come from `cfg_sreg`. The propagation length P is `cfg_sreg[3:0]`. Phase 1 is `cfg_sreg[6:4]`+1 quanta and phase 2 is `cfg_sreg[9:7]`+1 quanta. With no edges, the bit period is (D+1)·(1+P+ph1+ph2) clocks. `seg_state` reports the segment as SYNC=0, PROP=1, PH1=2, PH2=3.
- R3: A propagation field above 8 acts as 8. A bit therefore spans 3 to 25 quanta, and fields 8 and 15 give equal periods.
- R4: `bit_start` is high for exactly the first clock of each synchronisation segment. It is never high for two clocks in a row unless a hard sync intervenes.
- R5: `sample_strb` is a one-clock pulse that comes (D+1)·(1+P+ph1) clocks after `bit_start`. `sampled_bit` holds the value taken at that sample point and changes at no other time.
- R6: When `cfg_sreg[10]`=1, the sampled value is the majority of the line at the last clock of the three quanta that end at the sample point. When `cfg_sreg[10]`=0, it is the line at the sample point alone.
- R7: A falling edge on `rx_line` while `bus_idle`=1 causes a hard sync: `bit_start` rises in the next clock and the bit restarts.
- R8: A falling edge in PROP or PH1 while the bus is busy lengthens PH1 by min(SJW, e). SJW = `cfg_qreg[7:6]`+1. e is the position of the edge's quantum counted from the end of SYNC, starting at 1.
- R9: A falling edge in PH2 while the bus is busy is handled by the number of PH2 quanta left, counting the current one. If that number is at most SJW, the bit ends at once and SYNC starts in the next clock. Otherwise PH2 is shortened by SJW.
- R10: At most one resynchronisation takes effect per bit. Edges that arrive during SYNC cause none.
- R11: While reset is held, `seg_state`=0, `sample_strb`=0 and `sampled_bit`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_qreg | input | 8 | Quantum word: [5:0] prescale minus one, [7:6] jump width minus one |
| cfg_sreg | input | 11 | Segment word: [3:0] propagation, [6:4] phase 1 minus one, [9:7] phase 2 minus one, [10] triple sampling |
| rx_line | input | 1 | Received bus level, 0 dominant |
| bus_idle | input | 1 | High while the protocol logic considers the bus idle |
| tq_tick | output | 1 | Last clock of each quantum |
| bit_start | output | 1 | First clock of each bit |
| sample_strb | output | 1 | Sampled value valid this clock |
| sampled_bit | output | 1 | Last sampled bus value |
| seg_state | output | 2 | Current segment code |

## Verification
The embedded assertions check four things on every cycle:
- the prescaler counts up by one between its restarts;
- a hard sync always yields a bit boundary in the next clock;
- the sample strobe only appears on entry to phase 2;
- no stretch or cut ever exceeds the jump width, and a resynchronisation is recorded only after a busy-bus edge.

Only the directed scenarios can show the exact bit periods and sample offsets: the prescale and length corners, the propagation clamp, the majority vote against a single sample, and the one-resynchronisation-per-bit rule. Each scenario does this by timing the strobes against a hand-computed schedule.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
    localparam int BRP_W  = 6;   // prescale field width
    localparam int LEN_W  = 4;   // segment length / quantum counter width
    localparam int SJW_W  = 3;   // decoded jump width (1..4)
    localparam int QREG_W = 8;
    localparam int SREG_W = 11;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PROP = 2'd1,
        SEG_PH1  = 2'd2,
        SEG_PH2  = 2'd3
    } seg_e;

    typedef struct packed {
        logic [BRP_W-1:0] brp;
        logic [SJW_W-1:0] sjw;
        logic [LEN_W-1:0] prop;
        logic [LEN_W-1:0] ph1;
        logic [LEN_W-1:0] ph2;
        logic             triple;
    } bt_cfg_t;
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
    import can_bt_pkg::*;
#(
    parameter int PROP_MAX = 8
) (
    input  logic [QREG_W-1:0] qreg,
    input  logic [SREG_W-1:0] sreg,
    output bt_cfg_t           cfg
);
    localparam logic [LEN_W-1:0] PROP_CAP = LEN_W'(PROP_MAX);

    always_comb begin
        cfg.brp    = qreg[5:0];
        cfg.sjw    = {1'b0, qreg[7:6]} + 3'd1;
        cfg.prop   = (sreg[3:0] > PROP_CAP) ? PROP_CAP : sreg[3:0];
        cfg.ph1    = {1'b0, sreg[6:4]} + 4'd1;
        cfg.ph2    = {1'b0, sreg[9:7]} + 4'd1;
        cfg.triple = sreg[10];
    end
endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [BRP_W-1:0] div_m1,
    output logic             tick,
    output logic [BRP_W-1:0] cnt
);
    // >= so that lowering the divider mid-quantum cannot strand the counter
    assign tick = (cnt >= div_m1);

    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (restart || tick) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

    AST_QUANTUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !tick) |=> (cnt == $past(cnt) + 1'b1)); // R1
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    input  logic tick,
    input  logic sample_now,
    input  logic triple,
    output logic fall,
    output logic sample_strb,
    output logic sampled_bit
);
    logic       rx_prev;
    logic [1:0] hist;   // [0] previous quantum end, [1] the one before
    logic       vote;

    assign fall = rx_prev & ~rx_line;

    always_comb begin
        if (triple)
            vote = (hist[1] & hist[0]) | (hist[1] & rx_line) | (hist[0] & rx_line);
        else
            vote = rx_line;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_prev     <= 1'b1;
            hist        <= 2'b11;
            sample_strb <= 1'b0;
            sampled_bit <= 1'b1;
        end else begin
            rx_prev     <= rx_line;
            if (tick) hist <= {hist[0], rx_line};
            sample_strb <= sample_now;
            if (sample_now) sampled_bit <= vote;
        end
    end

    AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_now |=> $stable(sampled_bit)); // R5
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
    import can_bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             fall,
    input  logic             bus_idle,
    input  logic [SJW_W-1:0] sjw,
    input  logic [LEN_W-1:0] prop,
    input  logic [LEN_W-1:0] ph1,
    input  logic [LEN_W-1:0] ph2,
    output seg_e             state,
    output logic             restart,
    output logic             sample_now
);
    localparam int EW = LEN_W + 1;

    seg_e             state_q, state_d;
    logic [LEN_W-1:0] qcnt_q, qcnt_d;
    logic [SJW_W-1:0] add_q, add_d, sub_q, sub_d;
    logic             used_q, used_d;

    logic [EW-1:0] q1, err, ext, sjw_e, ph1_eff, ph2_eff, left;
    logic          resync_ok, hard;

    assign state = state_q;

    // next-state process
    always_comb begin
        state_d    = state_q;
        qcnt_d     = qcnt_q;
        add_d      = add_q;
        sub_d      = sub_q;
        used_d     = used_q;
        restart    = 1'b0;
        sample_now = 1'b0;

        sjw_e   = EW'(sjw);
        q1      = {1'b0, qcnt_q} + 1'b1;
        err     = (state_q == SEG_PROP) ? q1 : q1 + {1'b0, prop};
        ext     = (err > sjw_e) ? sjw_e : err;
        ph1_eff = {1'b0, ph1} + EW'(add_q);
        ph2_eff = {1'b0, ph2} - EW'(sub_q);
        left    = ph2_eff - {1'b0, qcnt_q};

        hard      = fall && bus_idle;
        resync_ok = fall && !bus_idle && !used_q;

        // positive phase error: stretch phase 1
        if (resync_ok && (state_q == SEG_PROP || state_q == SEG_PH1)) begin
            add_d   = ext[SJW_W-1:0];
            ph1_eff = {1'b0, ph1} + ext;
            used_d  = 1'b1;
        end
        // negative phase error, large: cut phase 2 by the jump width
        if (resync_ok && state_q == SEG_PH2 && left > sjw_e) begin
            sub_d   = sjw;
            ph2_eff = ph2_eff - sjw_e;
            used_d  = 1'b1;
        end

        if (hard || (resync_ok && state_q == SEG_PH2 && left <= sjw_e)) begin
            state_d = SEG_SYNC;
            qcnt_d  = '0;
            add_d   = '0;
            sub_d   = '0;
            used_d  = 1'b0;
            restart = 1'b1;
        end else if (tick) begin
            unique case (state_q)
                SEG_SYNC: begin
                    qcnt_d  = '0;
                    state_d = (prop != '0) ? SEG_PROP : SEG_PH1;
                end
                SEG_PROP: begin
                    if (q1 >= {1'b0, prop}) begin
                        state_d = SEG_PH1;
                        qcnt_d  = '0;
                    end else begin
                        qcnt_d = qcnt_q + 1'b1;
                    end
                end
                SEG_PH1: begin
                    if (q1 >= ph1_eff) begin
                        state_d    = SEG_PH2;
                        qcnt_d     = '0;
                        sample_now = 1'b1;
                    end else begin
                        qcnt_d = qcnt_q + 1'b1;
                    end
                end
                SEG_PH2: begin
                    if (q1 >= ph2_eff) begin
                        state_d = SEG_SYNC;
                        qcnt_d  = '0;
                        add_d   = '0;
                        sub_d   = '0;
                        used_d  = 1'b0;
                    end else begin
                        qcnt_d = qcnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEG_SYNC;
            qcnt_q  <= '0;
            add_q   <= '0;
            sub_q   <= '0;
            used_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            qcnt_q  <= qcnt_d;
            add_q   <= add_d;
            sub_q   <= sub_d;
            used_q  <= used_d;
        end
    end

    AST_STRETCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (add_q <= sjw) && (sub_q <= sjw)); // R8
    AST_RESYNC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(used_q) |-> ($past(fall) && !$past(bus_idle))); // R10
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
    import can_bt_pkg::*;
#(
    parameter int PROP_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [QREG_W-1:0] cfg_qreg,
    input  logic [SREG_W-1:0] cfg_sreg,
    input  logic              rx_line,
    input  logic              bus_idle,
    output logic              tq_tick,
    output logic              bit_start,
    output logic              sample_strb,
    output logic              sampled_bit,
    output logic [1:0]        seg_state
);
    bt_cfg_t          cfg;
    logic [BRP_W-1:0] pcnt;
    logic             restart, sample_now, fall;
    seg_e             state;

    can_bt_cfg #(.PROP_MAX(PROP_MAX)) u_cfg (
        .qreg (cfg_qreg),
        .sreg (cfg_sreg),
        .cfg  (cfg)
    );

    can_bt_prescaler u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .div_m1  (cfg.brp),
        .tick    (tq_tick),
        .cnt     (pcnt)
    );

    can_bt_sampler u_samp (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_line     (rx_line),
        .tick        (tq_tick),
        .sample_now  (sample_now),
        .triple      (cfg.triple),
        .fall        (fall),
        .sample_strb (sample_strb),
        .sampled_bit (sampled_bit)
    );

    can_bt_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tq_tick),
        .fall       (fall),
        .bus_idle   (bus_idle),
        .sjw        (cfg.sjw),
        .prop       (cfg.prop),
        .ph1        (cfg.ph1),
        .ph2        (cfg.ph2),
        .state      (state),
        .restart    (restart),
        .sample_now (sample_now)
    );

    assign seg_state = state;
    assign bit_start = (state == SEG_SYNC) && (pcnt == '0);

    AST_HARD_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && bus_idle) |=> bit_start); // R7
    AST_SAMPLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        sample_strb |-> (seg_state == SEG_PH2)); // R5
    AST_BOUNDARY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_start && !(fall && bus_idle)) |=> !bit_start); // R4
endmodule

// File: tb/can_bit_timing_bench.sv
`timescale 1ns/1ps
module can_bit_timing_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_qreg = 8'd0;
    logic [10:0] cfg_sreg = 11'd0;
    logic        rx_line = 1'b1;
    logic        bus_idle = 1'b0;
    logic        tq_tick, bit_start, sample_strb, sampled_bit;
    logic [1:0]  seg_state;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    can_bit_timing u_can_bit_timing (
        .clk(clk), .rst_n(rst_n), .cfg_qreg(cfg_qreg), .cfg_sreg(cfg_sreg),
        .rx_line(rx_line), .bus_idle(bus_idle), .tq_tick(tq_tick),
        .bit_start(bit_start), .sample_strb(sample_strb),
        .sampled_bit(sampled_bit), .seg_state(seg_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_q(input int div, input int sjw);
        return {2'(sjw - 1), 6'(div - 1)};
    endfunction

    function automatic logic [10:0] mk_s(input int tri3, input int pr, input int p1, input int p2);
        return {1'(tri3), 3'(p2 - 1), 3'(p1 - 1), 4'(pr)};
    endfunction

    task automatic do_reset(input logic [7:0] q, input logic [10:0] s);
        @(negedge clk);
        rst_n = 1'b0; rx_line = 1'b1; bus_idle = 1'b0;
        cfg_qreg = q; cfg_sreg = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_bs();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (bit_start) break;
        end
    endtask

    // Events: cycle numbers relative to bit_start where rx goes 0/1/0/1
    task automatic measure(input int f0, input int r0, input int f1, input int r1,
                           output int samp_k, output int per_k,
                           output int bitv, output int bs1);
        samp_k = -1; per_k = -1; bitv = -1; bs1 = -1;
        wait_bs();
        if (f0 == 0) rx_line = 1'b0;
        for (int k = 1; k <= 1000; k++) begin
            @(negedge clk);
            if (k == 1) bs1 = int'(bit_start);
            if (sample_strb && samp_k < 0) begin
                samp_k = k;
                bitv = int'(sampled_bit);
            end
            if (bit_start) begin
                per_k = k;
                break;
            end
            if (k == f0) rx_line = 1'b0;
            if (k == r0) rx_line = 1'b1;
            if (k == f1) rx_line = 1'b0;
            if (k == r1) rx_line = 1'b1;
        end
        rx_line = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 seg_state", int'(seg_state), 0);
        chk("R11 sample_strb", int'(sample_strb), 0);
        chk("R11 sampled_bit", int'(sampled_bit), 1);
    endtask

    task automatic t_period(input string tag, input int div, input int pr,
                            input int p1, input int p2, input int exp_per, input int exp_s);
        int s, p, b, b1;
        do_reset(mk_q(div, 1), mk_s(0, pr, p1, p2));
        measure(-1, -1, -1, -1, s, p, b, b1);
        chk({tag, " R2 period"}, p, exp_per);
        chk({tag, " R5 sample offset"}, s, exp_s);
        chk({tag, " R4 single-clock boundary"}, b1, 0);
    endtask

    task automatic t_clamp();
        int s8, p8, s15, p15, b, b1;
        do_reset(mk_q(1, 1), mk_s(0, 8, 8, 8));
        measure(-1, -1, -1, -1, s8, p8, b, b1);
        do_reset(mk_q(1, 1), mk_s(0, 15, 8, 8));
        measure(-1, -1, -1, -1, s15, p15, b, b1);
        chk("R3 max bit 25 quanta", p8, 25);
        chk("R3 prop 15 clamps to 8", p15, p8);
        chk("R3 clamped sample offset", s15, 17);
    endtask

    task automatic t_triple(input int tri3, input int exp_bit);
        int s, p, b, b1;
        do_reset(mk_q(2, 1), mk_s(tri3, 1, 2, 2));
        measure(0, 7, -1, -1, s, p, b, b1);
        chk("R6 sampled value", b, exp_bit);
        chk("R10 edge in sync ignored, period", p, 12);
    endtask

    task automatic t_lengthen(input string tag, input int sjw, input int fe,
                              input int exp_s, input int exp_p);
        int s, p, b, b1;
        do_reset(mk_q(1, sjw), mk_s(0, 1, 3, 3));
        measure(fe, -1, -1, -1, s, p, b, b1);
        chk({tag, " R8 sample offset"}, s, exp_s);
        chk({tag, " R8 period"}, p, exp_p);
    endtask

    task automatic t_shorten(input string tag, input int fe, input int exp_p);
        int s, p, b, b1;
        do_reset(mk_q(1, 2), mk_s(0, 1, 3, 3));
        measure(fe, -1, -1, -1, s, p, b, b1);
        chk({tag, " R9 period"}, p, exp_p);
        chk({tag, " R9 sample unaffected"}, s, 5);
    endtask

    task automatic t_once();
        int s, p, b, b1;
        do_reset(mk_q(1, 4), mk_s(0, 1, 3, 3));
        measure(2, 3, 4, -1, s, p, b, b1);
        chk("R10 second edge ignored, sample", s, 7);
        chk("R10 second edge ignored, period", p, 10);
    endtask

    task automatic t_hard();
        int s, p, b, b1;
        do_reset(mk_q(2, 1), mk_s(0, 1, 2, 2));
        bus_idle = 1'b1;
        measure(5, -1, -1, -1, s, p, b, b1);
        bus_idle = 1'b0;
        chk("R7 hard sync restarts bit", p, 6);
        chk("R7 no sample before restart", s, -1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_period("div2", 2, 1, 2, 2, 12, 8);          // R1 R2
        t_period("div1", 1, 3, 4, 2, 10, 8);          // R2
        t_period("div64 min", 64, 0, 1, 1, 192, 128); // R1 R3 min length
        t_clamp();
        t_triple(0, 1);
        t_triple(1, 0);
        t_lengthen("sjw2", 2, 2, 7, 10);
        t_lengthen("sjw4 e-bound", 4, 2, 7, 10);
        t_lengthen("sjw1", 1, 4, 6, 9);
        t_shorten("restart", 6, 7);
        t_shorten("cut", 5, 6);
        t_once();
        t_hard();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule